// File: doc/BRIEF.md
# Scanned Keyboard Matrix Encoder

This block scans a key switch matrix one column at a time and turns a debounced key press into a parallel code with an active-low strobe. A divider derived from the system clock sets the scan step. On each step the column counter moves to the next column, and the one-hot drive pattern follows it. The row sense lines are read for the column that is currently driven. One full pass over all columns is a scan cycle. The first closed key found during a scan cycle becomes that cycle's candidate.

A key is accepted only when the same matrix position is the candidate at the end of two scan cycles in a row. A press shorter than that gives no output, and a change of position restarts the qualification. An accepted key loads its code and drops the strobe for one scan step. While the key stays closed it produces no further strobe. After release, three empty scan cycles in a row are needed before the detector returns to idle. One dedicated position acts as a local-mode key: accepting it toggles an indicator output, and it leaves the code and the strobe alone.

Top module: `kbd_matrix_encoder`

## Requirements
- R1: After reset, keyStrobeN is 1, keyCode is 0, localInd is 0 and colDrive is 1 (column 0 driven).
- R2: colDrive is one-hot and active-high. It moves from column c to column c+1 every SCAN_DIV clocks and wraps from NUM_COLS-1 to 0. After n clocks out of reset, column floor(n/SCAN_DIV) mod NUM_COLS is driven. rowSense bit r high means the key at (driven column, r) is closed.
- R3: A key is accepted only if it is the candidate at the end of two consecutive scan cycles. A closure seen at the end of only one scan cycle gives no strobe.
- R4: If the candidate at the end of the second scan cycle sits at a different position, that new position replaces the stored one. It is accepted only if it is seen again at the end of the next scan cycle.
- R5: On acceptance, keyCode becomes CODE_BASE + col*NUM_ROWS + row, on the same clock edge where keyStrobeN falls. keyCode does not change at any other time.
- R6: keyStrobeN stays low for exactly SCAN_DIV clocks, up to the next scan step.
- R7: A key held closed for any number of scan cycles gives exactly one strobe.
- R8: After a release, the detector becomes idle only at the end of the third consecutive scan cycle with no key closed. A key seen before then counts as part of the same press and gives no strobe.
- R9: Accepting the key at (LOCAL_COL, LOCAL_ROW) toggles localInd. It gives no strobe and leaves keyCode unchanged.
- R10: When several keys are closed in one scan cycle, the candidate is the one in the lowest column, and within that column the lowest row.
- R11: A key in the last column is sampled on the same scan step that ends the scan cycle, and it counts toward that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowSense | input | NUM_ROWS | Row sense lines, high = closed switch in the driven column |
| colDrive | output | NUM_COLS | One-hot column drive |
| keyCode | output | CODE_W | Code of the last accepted key |
| keyStrobeN | output | 1 | Active-low key strobe |
| localInd | output | 1 | Local-mode indicator latch |

## Verification
The sample taken from the last column and the end-of-cycle evaluation happen on the same scan step. A hit there has to be merged with the candidate collected earlier in the cycle before the qualification state machine decides. The bench provokes this by holding a key in the final column for exactly two scan cycles, aligned to the column wrap. It then requires a strobe that carries that key's code. The same alignment, combined with a short release gap, drives re-detection during the release countdown. In that case the bench requires that no strobe appears.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef struct packed {
    logic loadCand;
    logic accept;
    logic toggleLocal;
  } kbdCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_HELD,
    ST_REL1,
    ST_REL2
  } kbdState_t;
endpackage

// File: rtl/kbd_scan_dp.sv
module kbd_scan_dp #(
  parameter int NUM_COLS  = 8,
  parameter int NUM_ROWS  = 8,
  parameter int SCAN_DIV  = 4,
  parameter int CODE_W    = 8,
  parameter int CODE_BASE = 32,
  parameter int LOCAL_COL = 0,
  parameter int LOCAL_ROW = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_ROWS-1:0]  rowSense,
  input  kbd_pkg::kbdCtrl_t    ctrl,
  output logic [NUM_COLS-1:0]  colDrive,
  output logic [CODE_W-1:0]    keyCode,
  output logic                 keyStrobeN,
  output logic                 localInd,
  output logic                 endCycle,
  output logic                 found,
  output logic                 posMatch,
  output logic                 isLocal
);
  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [COL_W-1:0] col;
  logic             tick, lastCol, colHit;
  logic [ROW_W-1:0] hitRow;
  logic             accFound;
  logic [COL_W-1:0] accCol, candCol, curCol;
  logic [ROW_W-1:0] accRow, candRow, curRow;

  assign tick     = (divCnt == DIV_W'(SCAN_DIV - 1));
  assign lastCol  = (col == COL_W'(NUM_COLS - 1));
  assign endCycle = tick & lastCol;

  // scan step divider and column counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      col    <= '0;
    end else if (tick) begin
      divCnt <= '0;
      col    <= lastCol ? '0 : col + COL_W'(1);
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_colDec
    assign colDrive[g] = (col == COL_W'(g));
  end

  // lowest closed row in the driven column
  always_comb begin
    hitRow = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (rowSense[r]) hitRow = ROW_W'(r);
    end
  end
  assign colHit = |rowSense;

  // candidate of this scan cycle, merged with the current column's sample
  assign found   = accFound | colHit;
  assign curCol  = accFound ? accCol : col;
  assign curRow  = accFound ? accRow : hitRow;
  assign posMatch = (curCol == candCol) && (curRow == candRow);
  assign isLocal  = (curCol == COL_W'(LOCAL_COL)) && (curRow == ROW_W'(LOCAL_ROW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accFound <= 1'b0;
      accCol   <= '0;
      accRow   <= '0;
    end else if (tick) begin
      if (lastCol) begin
        accFound <= 1'b0;
      end else if (!accFound && colHit) begin
        accFound <= 1'b1;
        accCol   <= col;
        accRow   <= hitRow;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candCol <= '0;
      candRow <= '0;
    end else if (ctrl.loadCand) begin
      candCol <= curCol;
      candRow <= curRow;
    end
  end

  // code register, strobe stage, local latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyCode    <= '0;
      keyStrobeN <= 1'b1;
      localInd   <= 1'b0;
    end else begin
      if (ctrl.accept) begin
        keyCode    <= CODE_W'(CODE_BASE) + CODE_W'(curCol) * CODE_W'(NUM_ROWS) + CODE_W'(curRow);
        keyStrobeN <= 1'b0;
      end else if (tick) begin
        keyStrobeN <= 1'b1;
      end
      if (ctrl.toggleLocal) localInd <= ~localInd;
    end
  end
endmodule

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              endCycle,
  input  logic              found,
  input  logic              posMatch,
  input  logic              isLocal,
  output kbd_pkg::kbdCtrl_t ctrl
);
  import kbd_pkg::*;

  kbdState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    if (endCycle) begin
      unique case (state)
        ST_IDLE: if (found) begin
          ctrl.loadCand = 1'b1;
          stateNext     = ST_QUAL;
        end
        ST_QUAL: begin
          if (found && posMatch) begin
            ctrl.accept      = !isLocal;
            ctrl.toggleLocal = isLocal;
            stateNext        = ST_HELD;
          end else if (found) begin
            ctrl.loadCand = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_HELD: stateNext = found ? ST_HELD : ST_REL1;
        ST_REL1: stateNext = found ? ST_HELD : ST_REL2;
        ST_REL2: stateNext = found ? ST_HELD : ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/kbd_matrix_encoder.sv
module kbd_matrix_encoder #(
  parameter int NUM_COLS  = 8,
  parameter int NUM_ROWS  = 8,
  parameter int SCAN_DIV  = 4,
  parameter int CODE_W    = 8,
  parameter int CODE_BASE = 32,
  parameter int LOCAL_COL = 0,
  parameter int LOCAL_ROW = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ROWS-1:0] rowSense,
  output logic [NUM_COLS-1:0] colDrive,
  output logic [CODE_W-1:0]   keyCode,
  output logic                keyStrobeN,
  output logic                localInd
);
  kbd_pkg::kbdCtrl_t ctrl;
  logic endCycle, found, posMatch, isLocal;

  kbd_scan_dp #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .SCAN_DIV(SCAN_DIV),
    .CODE_W(CODE_W), .CODE_BASE(CODE_BASE),
    .LOCAL_COL(LOCAL_COL), .LOCAL_ROW(LOCAL_ROW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rowSense(rowSense), .ctrl(ctrl),
    .colDrive(colDrive), .keyCode(keyCode), .keyStrobeN(keyStrobeN),
    .localInd(localInd), .endCycle(endCycle), .found(found),
    .posMatch(posMatch), .isLocal(isLocal)
  );

  kbd_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .endCycle(endCycle), .found(found),
    .posMatch(posMatch), .isLocal(isLocal), .ctrl(ctrl)
  );
endmodule

// File: rtl/kbd_matrix_encoder_chk.sv
module kbd_matrix_encoder_chk #(
  parameter int NUM_COLS = 8,
  parameter int CODE_W   = 8,
  parameter int SCAN_DIV = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_COLS-1:0] colDrive,
  input logic [CODE_W-1:0]   keyCode,
  input logic                keyStrobeN,
  input logic                localInd
);
  logic [15:0]         lowCnt;
  logic [NUM_COLS-1:0] prevCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      prevCol <= NUM_COLS'(1);
    end else begin
      lowCnt  <= keyStrobeN ? 16'd0 : lowCnt + 16'd1;
      prevCol <= colDrive;
    end
  end

  AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(colDrive) == 1); // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (colDrive != prevCol) |-> (colDrive == {prevCol[NUM_COLS-2:0], prevCol[NUM_COLS-1]})); // R2
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyStrobeN) |-> (lowCnt == 16'(SCAN_DIV))); // R6
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    !keyStrobeN |-> (lowCnt < 16'(SCAN_DIV))); // R6
  AST_CODE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(keyCode) |-> $fell(keyStrobeN)); // R5
  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(localInd) |-> ($stable(keyCode) && keyStrobeN)); // R9
endmodule

bind kbd_matrix_encoder kbd_matrix_encoder_chk #(
  .NUM_COLS(NUM_COLS), .CODE_W(CODE_W), .SCAN_DIV(SCAN_DIV)
) u_chk (
  .clk(clk), .rstN(rstN), .colDrive(colDrive), .keyCode(keyCode),
  .keyStrobeN(keyStrobeN), .localInd(localInd)
);

// File: tb/kbd_matrix_encoder_bench.sv
module kbd_matrix_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 8;
  localparam int NROW = 8;
  localparam int DIV  = 4;
  localparam int SCAN = NCOL * DIV;
  localparam int LCOL = 0;
  localparam int LROW = 7;

  typedef struct {
    logic [7:0] code;
    string      req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NROW-1:0] rowSense;
  logic [NCOL-1:0] colDrive;
  logic [7:0] keyCode;
  logic keyStrobeN, localInd;
  logic [NCOL*NROW-1:0] keyMat = '0;

  int compared = 0;
  int mismatched = 0;
  expItem_t expQ[$];
  bit monOn = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_matrix_encoder u_kbd_matrix_encoder (
    .clk(clk), .rstN(rstN), .rowSense(rowSense), .colDrive(colDrive),
    .keyCode(keyCode), .keyStrobeN(keyStrobeN), .localInd(localInd)
  );

  // switch matrix model
  always_comb begin
    rowSense = '0;
    for (int c = 0; c < NCOL; c++)
      if (colDrive[c]) rowSense = rowSense | keyMat[c*NROW +: NROW];
  end

  function automatic logic [7:0] codeOf(input int c, input int r);
    return 8'(32 + c * NROW + r);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected codes on each strobe and measures its width
  logic prevStrobe = 1'b1;
  int lowLen = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (prevStrobe && !keyStrobeN) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected strobe", keyCode, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(keyCode == it.code, it.req, "strobe code", keyCode, it.code);
        end
      end
      if (!keyStrobeN) lowLen++;
      if (!prevStrobe && keyStrobeN) begin
        check(lowLen == DIV, "R6", "strobe width", lowLen, DIV);
        lowLen = 0;
      end
      prevStrobe = keyStrobeN;
    end
  end

  task automatic pushExp(input int c, input int r, input string req);
    expItem_t it;
    it.code = codeOf(c, r);
    it.req  = req;
    expQ.push_back(it);
  endtask

  task automatic syncScan();
    @(posedge colDrive[0]);
    @(negedge clk);
  endtask

  task automatic holdMask(input logic [NCOL*NROW-1:0] m, input int cycles);
    keyMat = m;
    repeat (cycles * SCAN) @(negedge clk);
    keyMat = '0;
  endtask

  function automatic logic [NCOL*NROW-1:0] bitOf(input int c, input int r);
    logic [NCOL*NROW-1:0] m;
    m = '0;
    m[c*NROW + r] = 1'b1;
    return m;
  endfunction

  task automatic rest(input int cycles);
    keyMat = '0;
    repeat (cycles * SCAN) @(negedge clk);
  endtask

  task automatic queueEmpty(input string req);
    check(expQ.size() == 0, req, "pending strobes", expQ.size(), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [7:0] savedCode;
    logic savedLocal;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(keyStrobeN == 1'b1, "R1", "strobe", keyStrobeN, 1);
    check(keyCode == 8'h00, "R1", "code", keyCode, 0);
    check(localInd == 1'b0, "R1", "local", localInd, 0);
    check(colDrive == 8'h01, "R1", "colDrive", colDrive, 1);
    monOn = 1'b1;
    // R2 column walk
    bad = 0;
    for (int n = 0; n < 2 * SCAN + 5; n++) begin
      if (colDrive != 8'(1 << ((n / DIV) % NCOL))) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R2", "column walk errors", bad, 0);

    // R3 single-cycle closure is rejected
    syncScan();
    holdMask(bitOf(2, 3), 1);
    rest(4);
    queueEmpty("R3");
    check(keyStrobeN == 1'b1 && keyCode == 8'h00, "R3", "no key after glitch", keyCode, 0);

    // R5 normal press
    syncScan();
    pushExp(2, 3, "R5");
    holdMask(bitOf(2, 3), 3);
    rest(4);
    queueEmpty("R5");

    // R7 long hold gives one strobe
    syncScan();
    pushExp(4, 1, "R7");
    holdMask(bitOf(4, 1), 9);
    rest(4);
    queueEmpty("R7");

    // R8 re-press during release countdown, then after idle
    syncScan();
    pushExp(4, 1, "R8");
    holdMask(bitOf(4, 1), 3);
    rest(2);
    holdMask(bitOf(4, 1), 3);
    rest(3);
    queueEmpty("R8");
    pushExp(4, 1, "R8");
    holdMask(bitOf(4, 1), 2);
    rest(4);
    queueEmpty("R8");

    // R4 candidate mismatch restarts qualification
    syncScan();
    keyMat = bitOf(1, 0);
    repeat (SCAN) @(negedge clk);
    pushExp(1, 5, "R4");
    holdMask(bitOf(1, 5), 2);
    rest(4);
    queueEmpty("R4");

    // R10 priority: lower column wins, then lower row
    syncScan();
    pushExp(3, 6, "R10");
    holdMask(bitOf(5, 2) | bitOf(3, 6), 2);
    rest(4);
    pushExp(6, 1, "R10");
    holdMask(bitOf(6, 4) | bitOf(6, 1), 2);
    rest(4);
    queueEmpty("R10");

    // R11 key in the last column
    syncScan();
    pushExp(7, 6, "R11");
    holdMask(bitOf(7, 6), 2);
    rest(4);
    queueEmpty("R11");

    // R9 local key toggles indicator only
    savedCode = keyCode;
    savedLocal = localInd;
    syncScan();
    holdMask(bitOf(LCOL, LROW), 3);
    rest(4);
    check(localInd == ~savedLocal, "R9", "indicator toggled", localInd, ~savedLocal);
    check(keyCode == savedCode, "R9", "code unchanged", keyCode, savedCode);
    holdMask(bitOf(LCOL, LROW), 3);
    rest(4);
    check(localInd == savedLocal, "R9", "indicator toggled back", localInd, savedLocal);
    check(keyCode == savedCode, "R9", "code unchanged again", keyCode, savedCode);
    queueEmpty("R9");

    finishRun();
  end
endmodule